// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block turns an asynchronous serial line into parallel characters. It runs in the system clock domain. It advances only on cycles where a receive-clock enable is high, so the receive bit rate is set on its own and need not match any transmit rate. Each bit lasts 1, 16 or 64 enable ticks, chosen by a two-bit factor select. In the 16 and 64 modes a falling edge is checked again at the middle of the start bit. A start bit that has returned high by then is thrown away, and each later bit is sampled at its centre.

A finished character is placed in a holding register, and a ready flag is raised until the CPU reads it. Parity, framing and overrun faults set sticky flags, which only an error-clear strobe removes. A line held low through a whole character, stop bit included, raises a break output. After any character that ends with a low stop bit, the receiver ignores the line until it sees it high again. A status byte carries the flags together with the present level of the data-set-ready input.

Top module: `serial_rx_core`

## Requirements
- R1: `baud_sel` 2'b00 selects 1 tick per bit, 2'b01 selects 16, and 2'b10 or 2'b11 select 64. Data arrives least significant bit first. With F ticks per bit, and counting the tick that first sees the line low as tick 0, data bit k is sampled at tick F/2 + (k+1)·F (for F=1: tick k+1). The character appears on `rx_data` on the clock edge of the stop-bit sample.
- R2: With F of 16 or 64, the line is sampled again at tick F/2. If it is high there, no character is assembled, and the receiver goes back to hunting for a start bit.
- R3: `rx_rdy` (also `status[0]`) rises on the edge that completes a character. It falls on the edge after a cycle with `rd_data` high, unless a character completes on that same edge.
- R4: When `par_en` is 1, one parity bit follows the data. `par_even`=1 means data plus parity hold an even number of ones, and 0 means odd. A mismatch sets the parity flag `status[3]`.
- R5: A stop bit sampled low sets the framing flag `status[5]`. The receiver then waits for a tick with the line high before it hunts for a new start bit.
- R6: A character that completes while `rx_rdy` is high, with no read in that cycle, sets the overrun flag `status[4]`. The new character replaces the held one.
- R7: The parity, framing and overrun flags stay set until a cycle with `err_clr` high. If a flag is set and cleared on the same edge, setting wins.
- R8: `status[7]` follows the `dsr` input level with no delay. `status[2:1]` read 0.
- R9: `brk_det` (also `status[6]`) rises when all data bits, the parity bit and the stop bit are sampled low. It falls on the edge of the first tick that samples the line high.
- R10: On a cycle with `rxc_en` low, the receiver's bit timing and sampling do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxc_en | input | 1 | Receive clock enable, one tick per high cycle |
| rxd | input | 1 | Serial data line, synchronous to clk |
| baud_sel | input | 2 | Ticks-per-bit select |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 = even parity, 0 = odd |
| dsr | input | 1 | Data-set-ready level reported in status |
| rd_data | input | 1 | CPU read of the held character |
| err_clr | input | 1 | Clears the sticky error flags |
| rx_data | output | DATA_W | Held character |
| rx_rdy | output | 1 | Held character not yet read |
| status | output | 8 | {dsr, break, framing, overrun, parity, 0, 0, ready} |
| brk_det | output | 1 | Break condition detected |

## Verification
The assertions assume that `rxd` is already synchronous to `clk`, and that `baud_sel`, `par_en` and `par_even` do not change while a character is being received. The stimulus changes the line and the enable only on falling clock edges. It changes the mode inputs only between characters, after the line has been high long enough for the receiver to be hunting again. Reads and error-clear strobes are given in cycles with the enable low, so the handshake and the error checks can be observed apart.

// File: rtl/rx_pkg.sv
// Shared definitions for the asynchronous receiver.
// Assumes at most 64 ticks per bit.
package rx_pkg;
    localparam int F_X16 = 16;
    localparam int F_X64 = 64;
    localparam int CNT_W = $clog2(F_X64);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_BITS,
        ST_HOLD
    } rx_state_e;
endpackage

// File: rtl/rx_frame_fsm.sv
// Bit timing and character assembly.
// Hunts for a start edge, confirms it at mid-bit (x16/x64), samples each bit
// at its centre and reports completion in the stop-bit sample cycle.
// Assumes rxd is synchronous to clk and mode inputs are stable per character.
module rx_frame_fsm
    import rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic [1:0]        baud_sel,
    input  logic              par_en,
    output logic              done,
    output logic [DATA_W:0]   frame_bits,
    output logic              stop_bit,
    output logic              release_hold
);
    localparam int IDX_W = $clog2(DATA_W + 2);

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W:0]   shreg;
    logic [CNT_W-1:0]  lim_bit;
    logic [CNT_W-1:0]  lim_half;
    logic              one_x;
    logic [IDX_W-1:0]  last_idx;
    logic              at_sample;

    // Decode the ticks-per-bit select into counter limits.
    always_comb begin
        case (baud_sel)
            2'b00:   begin lim_bit = '0;                 one_x = 1'b1; end
            2'b01:   begin lim_bit = CNT_W'(F_X16 - 1);  one_x = 1'b0; end
            default: begin lim_bit = CNT_W'(F_X64 - 1);  one_x = 1'b0; end
        endcase
        lim_half = lim_bit >> 1;
        last_idx = IDX_W'(DATA_W) + IDX_W'(par_en);
        at_sample = (state == ST_BITS) && tick && (cnt == lim_bit);
    end

    // Completion and hold-release strobes seen by the holding stage.
    always_comb begin
        done         = at_sample && (idx == last_idx);
        stop_bit     = rxd;
        frame_bits   = shreg;
        release_hold = (state == ST_HOLD) && tick && rxd;
    end

    // Receive sequencer: start hunt, start check, bit sampling, wait-for-high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
        end else if (tick) begin
            case (state)
                ST_IDLE: begin
                    if (!rxd) begin
                        shreg <= '0;
                        idx   <= '0;
                        cnt   <= '0;
                        state <= one_x ? ST_BITS : ST_START;
                    end
                end
                ST_START: begin
                    if (cnt == lim_half) begin
                        cnt   <= '0;
                        state <= rxd ? ST_IDLE : ST_BITS;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_BITS: begin
                    if (cnt == lim_bit) begin
                        cnt <= '0;
                        if (idx == last_idx) begin
                            state <= rxd ? ST_IDLE : ST_HOLD;
                        end else begin
                            shreg[idx] <= rxd;
                            idx        <= idx + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (rxd) state <= ST_IDLE;
                end
            endcase
        end
    end

    AST_NO_MOVE_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state) && $stable(cnt)); // R10

    AST_FALSE_START_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START) && tick && rxd && (cnt == lim_half) |=> !done && (state == ST_IDLE)); // R2
endmodule

// File: rtl/rx_holding.sv
// Holding register, ready handshake, sticky error flags and break flag.
// Takes completion strobes from the sequencer in the cycle of the stop sample.
// Assumes par_en/par_even are stable while a character is received.
module rx_holding #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W:0]   frame_bits,
    input  logic              stop_bit,
    input  logic              release_hold,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              rd_data,
    input  logic              err_clr,
    output logic [DATA_W-1:0] data,
    output logic              rdy,
    output logic              pe,
    output logic              fe,
    output logic              oe,
    output logic              brk
);
    logic par_bad;
    logic all_low;

    // Judge parity and break on the completed frame.
    always_comb begin
        par_bad = par_en && ((^frame_bits) ^ ~par_even);
        all_low = (frame_bits == '0) && !stop_bit;
    end

    // Data register and ready handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
            rdy  <= 1'b0;
        end else if (done) begin
            data <= frame_bits[DATA_W-1:0];
            rdy  <= 1'b1;
        end else if (rd_data) begin
            rdy  <= 1'b0;
        end
    end

    // Sticky error flags; a new error wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pe <= 1'b0;
            fe <= 1'b0;
            oe <= 1'b0;
        end else begin
            pe <= (pe && !err_clr) || (done && par_bad);
            fe <= (fe && !err_clr) || (done && !stop_bit);
            oe <= (oe && !err_clr) || (done && rdy && !rd_data);
        end
    end

    // Break flag: set on an all-low frame, dropped when the line goes high.
    always_ff @(posedge clk) begin
        if (!rst_n)                brk <= 1'b0;
        else if (done && all_low)  brk <= 1'b1;
        else if (release_hold)     brk <= 1'b0;
    end

    AST_RDY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rdy); // R3

    AST_OVERRUN_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(rdy)); // R6

    AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fe && !err_clr |=> fe); // R7

    AST_BRK_WITH_FE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk) |-> fe); // R9
endmodule

// File: rtl/serial_rx_core.sv
// Top of the asynchronous receiver: sequencer plus holding stage, and the
// status byte {dsr, brk, fe, oe, pe, 0, 0, rdy}.
// Assumes rxd is synchronous to clk; rxc_en gives one tick per high cycle.
module serial_rx_core #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxc_en,
    input  logic              rxd,
    input  logic [1:0]        baud_sel,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              dsr,
    input  logic              rd_data,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_rdy,
    output logic [7:0]        status,
    output logic              brk_det
);
    logic            done;
    logic [DATA_W:0] frame_bits;
    logic            stop_bit;
    logic            release_hold;
    logic            pe, fe, oe;

    rx_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(rxc_en), .rxd(rxd),
        .baud_sel(baud_sel), .par_en(par_en), .done(done),
        .frame_bits(frame_bits), .stop_bit(stop_bit),
        .release_hold(release_hold)
    );

    rx_holding #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .done(done), .frame_bits(frame_bits),
        .stop_bit(stop_bit), .release_hold(release_hold), .par_en(par_en),
        .par_even(par_even), .rd_data(rd_data), .err_clr(err_clr),
        .data(rx_data), .rdy(rx_rdy), .pe(pe), .fe(fe), .oe(oe), .brk(brk_det)
    );

    // Assemble the status byte.
    always_comb status = {dsr, brk_det, fe, oe, pe, 2'b00, rx_rdy};

    AST_DSR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        status[7] == dsr); // R8
endmodule

// File: tb/test_serial_rx_core.sv
module test_serial_rx_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxc_en = 1'b0, rxd = 1'b1;
    logic [1:0] baud_sel = 2'b01;
    logic       par_en = 1'b0, par_even = 1'b1, dsr = 1'b0;
    logic       rd_data = 1'b0, err_clr = 1'b0;
    logic [7:0] rx_data, status;
    logic       rx_rdy, brk_det;

    int checks = 0, failures = 0;
    int div = 1, ph = 0;
    bit finished = 0;

    // reference model state
    bit       m_busy, m_hold, m_rdy, m_pe, m_fe, m_oe, m_brk;
    int       m_t;
    bit [8:0] m_word;
    bit [7:0] m_data;

    always #2 clk = ~clk;

    serial_rx_core i_serial_rx_core (
        .clk(clk), .rst_n(rst_n), .rxc_en(rxc_en), .rxd(rxd),
        .baud_sel(baud_sel), .par_en(par_en), .par_even(par_even), .dsr(dsr),
        .rd_data(rd_data), .err_clr(err_clr), .rx_data(rx_data),
        .rx_rdy(rx_rdy), .status(status), .brk_det(brk_det)
    );

    function automatic int factor(input logic [1:0] s);
        return (s == 2'b00) ? 1 : (s == 2'b01) ? 16 : 64;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: counts ticks since the start edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_hold = 0; m_rdy = 0; m_pe = 0; m_fe = 0;
            m_oe = 0; m_brk = 0; m_t = 0; m_word = 0; m_data = 0;
        end else begin
            int f, h, n, k;
            bit done, rel, stopv, bad;
            f = factor(baud_sel); h = f / 2; n = 8 + int'(par_en);
            done = 0; rel = 0; stopv = 1;
            if (rxc_en) begin
                if (m_hold) begin
                    if (rxd) begin m_hold = 0; rel = 1; end
                end else if (!m_busy) begin
                    if (!rxd) begin m_busy = 1; m_t = 0; m_word = 0; end
                end else begin
                    m_t++;
                    if (f > 1 && m_t == h) begin
                        if (rxd) m_busy = 0;
                    end else if (m_t > h && ((m_t - h) % f) == 0) begin
                        k = (m_t - h) / f - 1;
                        if (k < n) m_word[k] = rxd;
                        else begin
                            done = 1; stopv = rxd; m_busy = 0;
                            if (!rxd) m_hold = 1;
                        end
                    end
                end
            end
            bad = par_en && ((^m_word) != !par_even);
            m_pe = (m_pe && !err_clr) || (done && bad);
            m_fe = (m_fe && !err_clr) || (done && !stopv);
            m_oe = (m_oe && !err_clr) || (done && m_rdy && !rd_data);
            if (done) begin m_data = m_word[7:0]; m_rdy = 1; end
            else if (rd_data) m_rdy = 0;
            if (done && m_word == 0 && !stopv) m_brk = 1;
            else if (rel) m_brk = 0;
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        #1;
        if (rst_n && !finished) begin
            check("R1 rx_data", rx_data, m_data);
            check("R3 rx_rdy", rx_rdy, m_rdy);
            check("R3 status[0]", status[0], m_rdy);
            check("R4 status[3]", status[3], m_pe);
            check("R5 status[5]", status[5], m_fe);
            check("R6 status[4]", status[4], m_oe);
            check("R8 status[7]", status[7], dsr);
            check("R8 status[2:1]", status[2:1], 0);
            check("R9 brk_det", brk_det, m_brk);
            check("R9 status[6]", status[6], m_brk);
        end
    end

    task automatic tick_with(input logic v);
        do begin
            @(negedge clk);
            rxd = v; rd_data = 0; err_clr = 0;
            ph = (ph + 1) % div;
            rxc_en = (ph == 0);
        end while (!rxc_en);
    endtask

    task automatic send(input logic [7:0] d, input logic p, input logic s);
        int f;
        f = factor(baud_sel);
        repeat (f) tick_with(1'b0);
        for (int i = 0; i < 8; i++) repeat (f) tick_with(d[i]);
        if (par_en) repeat (f) tick_with(p);
        repeat (f) tick_with(s);
        repeat (4) tick_with(1'b1);
    endtask

    task automatic read_byte();
        @(negedge clk); rxc_en = 0; rd_data = 1;
        @(negedge clk); rd_data = 0;
    endtask

    task automatic clear_errs();
        @(negedge clk); rxc_en = 0; err_clr = 1;
        @(negedge clk); err_clr = 0;
    endtask

    function automatic logic par_of(input logic [7:0] d, input logic even);
        return (^d) ^ !even;
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        check("R3 reset rx_rdy", rx_rdy, 0);
        check("R9 reset brk_det", brk_det, 0);
        check("R7 reset flags", status[5:3], 0);

        // R1: x16, no parity
        baud_sel = 2'b01; send(8'hA5, 1'b0, 1'b1);
        check("R1 x16 data", rx_data, 8'hA5);
        check("R3 ready after char", rx_rdy, 1);
        read_byte(); #1;
        check("R3 cleared by read", rx_rdy, 0);

        // R1: x1
        baud_sel = 2'b00; send(8'h3C, 1'b0, 1'b1); #1;
        check("R1 x1 data", rx_data, 8'h3C);
        read_byte();

        // R4: x64 with even parity, good then bad
        baud_sel = 2'b10; par_en = 1; par_even = 1;
        send(8'h5B, par_of(8'h5B, 1), 1'b1); #1;
        check("R4 good even parity", status[3], 0);
        read_byte();
        send(8'h5B, !par_of(8'h5B, 1), 1'b1); #1;
        check("R4 bad even parity", status[3], 1);
        read_byte();
        repeat (50) tick_with(1'b1); #1;
        check("R7 parity flag sticky", status[3], 1);
        clear_errs(); #1;
        check("R7 flags cleared", status[5:3], 0);

        // R4: odd parity, x16
        baud_sel = 2'b01; par_even = 0;
        send(8'h81, !par_of(8'h81, 0), 1'b1); #1;
        check("R4 bad odd parity", status[3], 1);
        read_byte(); clear_errs();
        send(8'h81, par_of(8'h81, 0), 1'b1); #1;
        check("R4 good odd parity", status[3], 0);
        read_byte();
        par_en = 0;

        // R5: framing error, then line returns high
        send(8'h7E, 1'b0, 1'b0);
        repeat (8) tick_with(1'b1); #1;
        check("R5 framing flag", status[5], 1);
        check("R5 no break on data", brk_det, 0);
        read_byte(); clear_errs();

        // R6: overrun
        send(8'h11, 1'b0, 1'b1);
        send(8'h22, 1'b0, 1'b1); #1;
        check("R6 overrun flag", status[4], 1);
        check("R6 newer data kept", rx_data, 8'h22);
        read_byte(); clear_errs();

        // R2: false starts at x16 and x64
        repeat (4) tick_with(1'b0);
        repeat (40) tick_with(1'b1); #1;
        check("R2 x16 false start ignored", rx_rdy, 0);
        check("R2 x16 data unchanged", rx_data, 8'h22);
        baud_sel = 2'b11;
        repeat (20) tick_with(1'b0);
        repeat (140) tick_with(1'b1); #1;
        check("R2 x64 false start ignored", rx_rdy, 0);

        // R9: break
        baud_sel = 2'b01;
        repeat (16 * 10) tick_with(1'b0);
        repeat (30) tick_with(1'b0); #1;
        check("R9 break raised", brk_det, 1);
        tick_with(1'b1);
        @(negedge clk); #1;
        check("R9 break dropped", brk_det, 0);
        read_byte(); clear_errs();

        // R10: sparse receive clock
        div = 3; send(8'hC3, 1'b0, 1'b1); #1;
        check("R10 sparse ticks data", rx_data, 8'hC3);
        read_byte(); div = 1;

        // R8: dsr level
        @(negedge clk); dsr = 1; #1;
        check("R8 dsr high", status[7], 1);
        @(negedge clk); dsr = 0; #1;
        check("R8 dsr low", status[7], 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule